// File: doc/BRIEF.md
# Post-Trigger Trace Capture Controller

This block runs a wide circular trace buffer that records the fault-free state of every injectable line, one entry per target bus cycle. The trace-clock strobe marks each bus cycle. The sample is taken ahead of the injection switches, so each stored entry holds the line values before any fault is applied, whichever way a pin is driving. Recording runs without pause while the target executes.

When the trigger reports the start of an injection, the controller keeps recording until the buffer has been rewritten once from that point. It then freezes and holds the contents for the host. The host reads the buffer in logical order, oldest entry first. The controller also reports the physical buffer address that holds the injection cycle. An optional mode replaces the eight lowest data lanes with a timestamp counter that advances once per bus cycle. A re-arm command releases the frozen buffer and restarts recording.

Top module: `trace_capture_ctrl`

## Requirements
- R1: While and after reset, and before any strobe, frozen_o is 0, rd_valid_o is 0 and inj_addr_o is 0.
- R2: While not frozen, every cycle with strobe_i=1 writes exactly one entry at the next physical address, wrapping modulo DEPTH. Cycles with strobe_i=0 write nothing.
- R3: An inject event is inject_i=1 together with strobe_i=1 while recording and not yet triggered. Its own entry counts as the first of DEPTH post-trigger writes. frozen_o rises after the edge that performs the DEPTH-th such write, and not earlier.
- R4: inj_addr_o holds the physical address of the inject entry. That address equals the count of entries written since reset, modulo DEPTH, before the inject entry.
- R5: While frozen, rd_en_i=1 with logical index rd_idx_i returns that entry on rd_data_o one cycle later, with rd_valid_o=1. Index 0 is the oldest entry, which is the inject entry, and indices run from oldest to newest.
- R6: With ts_en_i=1, bits [7:0] of a stored entry hold the low 8 bits of a timestamp counter instead of sample_i[7:0]. Bits [95:8] keep the sample. The counter starts at 0 at reset and advances on every strobe in every state. An entry stores the counter value from before its own strobe.
- R7: While frozen, strobes and inject_i change neither the stored contents nor inj_addr_o.
- R8: rd_en_i is ignored while not frozen: rd_valid_o stays 0.
- R9: rearm_i while frozen clears frozen_o on the next cycle and restarts recording. rearm_i at any other time has no effect.
- R10: inject_i without strobe_i, or during the post-trigger phase, is ignored. The freeze point and inj_addr_o follow the first accepted inject event only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Trace-clock strobe, one per target bus cycle |
| sample_i | input | 96 | Fault-free line states taken before the injection switches |
| inject_i | input | 1 | Injection start from the trigger, qualified by strobe_i |
| ts_en_i | input | 1 | Store the timestamp in bits [7:0] |
| rearm_i | input | 1 | Release the frozen buffer and restart recording |
| rd_en_i | input | 1 | Host read request |
| rd_idx_i | input | 12 | Logical read index, 0 = oldest |
| rd_data_o | output | 96 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| frozen_o | output | 1 | Buffer frozen and readable |
| inj_addr_o | output | 12 | Physical address of the inject entry |

## Verification
A write pointer that slips, or a post-trigger count that is off by one, moves the freeze point by a strobe. It also shifts the whole logical readout by one entry, so the first read of index 0 after the freeze no longer returns the inject-cycle sample. A stale or wrongly latched inject address shows on inj_addr_o as soon as frozen_o rises. A timestamp counter that skips or stalls corrupts bits [7:0] on every later entry, and a full readout exposes this. A lost freeze state shows within one strobe, because the extra strobes sent while frozen would overwrite the oldest entries.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_POST   = 2'd1,
    ST_FROZEN = 2'd2
  } trace_state_e;
endpackage

// File: rtl/trace_stamp.sv
module trace_stamp #(
  parameter int WIDTH = 96,
  parameter int TS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             ts_en_i,
  input  logic [WIDTH-1:0] sample_i,
  output logic [WIDTH-1:0] word_o
);
  if (TS_W > 0) begin : g_ts
    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ts_q <= '0;
      else if (strobe_i) ts_q <= ts_q + 1'b1;
    end

    always_comb begin
      word_o = sample_i;
      if (ts_en_i) word_o[TS_W-1:0] = ts_q;
    end

    // R6: counter advances exactly once per strobe
    assert_ts_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(strobe_i) |-> ts_q == $past(ts_q) + 1'b1);
    assert_ts_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(strobe_i) |-> $stable(ts_q));
  end else begin : g_no_ts
    logic unused_ts;
    assign unused_ts = ^{clk_i, rst_ni, strobe_i, ts_en_i};
    assign word_o = sample_i;
  end
endmodule

// File: rtl/trace_seq.sv
module trace_seq
  import trace_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          inject_i,
  input  logic          rearm_i,
  output logic          we_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] oldest_o,
  output logic [AW-1:0] inj_addr_o,
  output logic          frozen_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  trace_state_e  state_q;
  logic [AW-1:0] ptr_q, cnt_q, inj_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ptr_q   <= '0;
      cnt_q   <= '0;
      inj_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: if (strobe_i) begin
          ptr_q <= ptr_q + 1'b1;
          if (inject_i) begin
            inj_q   <= ptr_q;
            cnt_q   <= AW'(1);
            state_q <= ST_POST;
          end
        end
        ST_POST: if (strobe_i) begin
          ptr_q <= ptr_q + 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FROZEN;
        end
        ST_FROZEN: if (rearm_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign we_o       = strobe_i && (state_q != ST_FROZEN);
  assign wr_addr_o  = ptr_q;
  assign oldest_o   = ptr_q;
  assign inj_addr_o = inj_q;
  assign frozen_o   = (state_q == ST_FROZEN);

  // R3: freeze only on a strobe edge
  assert_freeze_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frozen_o) |-> $past(strobe_i));
  // R4: at freeze the oldest slot is the inject slot
  assert_oldest_is_inject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frozen_o) |-> ptr_q == inj_q);
  // R7: frozen state holds pointer and inject address
  assert_frozen_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !rearm_i) |=> (frozen_o && $stable(ptr_q) && $stable(inj_q)));
  // R9: rearm releases on the next cycle
  assert_rearm_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && rearm_i) |=> !frozen_o);
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [WIDTH-1:0] wd_i,
  input  logic             re_i,
  input  logic [AW-1:0]    ra_i,
  output logic [WIDTH-1:0] rd_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
    if (re_i) rd_o <= mem_q[ra_i];
  end

  // R7: no simultaneous write and read while reading frozen contents
  assert_no_rw_mix_R7: assert property (@(posedge clk_i)
    re_i |-> !we_i);
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl #(
  parameter int WIDTH = 96,
  parameter int DEPTH = 4096,
  parameter int TS_W  = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] sample_i,
  input  logic             inject_i,
  input  logic             ts_en_i,
  input  logic             rearm_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             frozen_o,
  output logic [AW-1:0]    inj_addr_o
);
  logic [WIDTH-1:0] word;
  logic             we;
  logic [AW-1:0]    wr_addr, oldest;
  logic             re;

  trace_stamp #(.WIDTH(WIDTH), .TS_W(TS_W)) u_stamp (
    .clk_i, .rst_ni, .strobe_i, .ts_en_i, .sample_i, .word_o(word)
  );

  trace_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i, .rst_ni, .strobe_i, .inject_i, .rearm_i,
    .we_o(we), .wr_addr_o(wr_addr), .oldest_o(oldest),
    .inj_addr_o, .frozen_o
  );

  assign re = rd_en_i && frozen_o;

  trace_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk_i, .we_i(we), .wa_i(wr_addr), .wd_i(word),
    .re_i(re), .ra_i(oldest + rd_idx_i), .rd_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_o <= 1'b0;
    else         rd_valid_o <= re;
  end

  // R8: valid data only follows a frozen cycle
  assert_rd_only_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(frozen_o));
  // R2: nothing is written while frozen
  assert_no_write_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> !we);
endmodule

// File: tb/sim_trace_capture_ctrl.sv
module sim_trace_capture_ctrl;
  localparam int W = 96;
  localparam int D = 4096;
  localparam int AW = 12;
  localparam int ROWS = 3;
  // per row: pre-trigger strobes, timestamp mode, extra ignored inject/rearm in post phase
  localparam int PRE  [ROWS] = '{5, 4100, 0};
  localparam bit TSM  [ROWS] = '{1'b0, 1'b1, 1'b0};
  localparam bit XTRA [ROWS] = '{1'b0, 1'b1, 1'b1};

  logic clk = 0, rst_ni = 0;
  logic strobe = 0, inject = 0, ts_en = 0, rearm = 0, rd_en = 0;
  logic [W-1:0] sample = '0;
  logic [AW-1:0] rd_idx = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, frozen;
  logic [AW-1:0] inj_addr;

  int errors = 0, checks = 0;
  int g = 0;            // strobes since reset
  int ptr_m = 0;        // model write pointer
  bit rec = 1;          // model: recording enabled

  always #10 clk = ~clk;

  trace_capture_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .sample_i(sample),
    .inject_i(inject), .ts_en_i(ts_en), .rearm_i(rearm), .rd_en_i(rd_en),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .frozen_o(frozen), .inj_addr_o(inj_addr)
  );

  function automatic logic [W-1:0] pat(int k);
    return {32'(k) ^ 32'hC3A50000, 32'(k * 7 + 1), ~32'(k)};
  endfunction

  function automatic logic [W-1:0] stored(int k, bit ts);
    logic [W-1:0] v = pat(k);
    if (ts) v[7:0] = 8'(k);
    return v;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one cycle from negedge to negedge
  task automatic cyc(bit s, bit inj, bit ra);
    strobe = s; inject = inj; rearm = ra; sample = pat(g);
    @(negedge clk);
    if (s) begin
      g++;
      if (rec) ptr_m = (ptr_m + 1) % D;
    end
    strobe = 0; inject = 0; rearm = 0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gi, exp_inj, bad;
    logic [W-1:0] first_bad_a, first_bad_e;
    repeat (2) @(negedge clk);
    chk("R1 frozen", W'(frozen), '0);
    chk("R1 rd_valid", W'(rd_valid), '0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 inj_addr", W'(inj_addr), '0);

    for (int r = 0; r < ROWS; r++) begin
      ts_en = TSM[r];
      for (int i = 0; i < PRE[r]; i++) cyc(1, 0, 0);
      rd_en = 1; @(negedge clk); rd_en = 0;
      chk("R8 read ignored unfrozen", W'(rd_valid), '0);
      gi = g; exp_inj = ptr_m;
      cyc(1, 1, 0);
      for (int i = 1; i < D - 1; i++) begin
        if (XTRA[r] && i == 10) begin
          cyc(0, 0, 1);           // R9 rearm outside frozen ignored
          cyc(1, 1, 0);           // R10 second inject ignored
        end else cyc(1, 0, 0);
      end
      chk("R3 not frozen before last", W'(frozen), '0);
      cyc(1, 0, 0);
      rec = 0;
      chk("R3 frozen after DEPTH writes", W'(frozen), 1);
      chk("R4 inj_addr", W'(inj_addr), W'(exp_inj));
      for (int i = 0; i < 3; i++) cyc(1, 1, 0);
      chk("R7 inj_addr stable frozen", W'(inj_addr), W'(exp_inj));
      bad = 0;
      for (int j = 0; j < D; j++) begin
        rd_en = 1; rd_idx = AW'(j);
        @(negedge clk);
        if (!rd_valid || rd_data !== stored(gi + j, TSM[r])) begin
          if (bad == 0) begin first_bad_a = rd_data; first_bad_e = stored(gi + j, TSM[r]); end
          bad++;
        end
      end
      rd_en = 0;
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R5 R2 R6 R7 readout row %0d bad=%0d act=%0h exp=%0h", r, bad, first_bad_a, first_bad_e);
      end
      cyc(0, 0, 1);
      rec = 1;
      chk("R9 rearm clears frozen", W'(frozen), '0);
    end

    // R10: inject without strobe is ignored
    cyc(0, 1, 0);
    for (int i = 0; i < D; i++) cyc(1, 0, 0);
    chk("R10 no freeze without strobed inject", W'(frozen), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule